// File: doc/BRIEF.md
# Per-core interval tick timer

A local tick source for one processor core. A prescaler divides the input clock by a programmable amount. Each prescaled tick decrements an interval counter. When the interval counter runs out, the block sets a status flag, and that flag drives the interrupt output when interrupts are enabled. In auto-repeat mode the interval counter reloads and keeps counting. In single-shot mode the block clears its own start bits after the first expiry. Software sees six 32-bit registers through a simple synchronous register port. Every write to a configuration register is acknowledged through a sticky write-status register.

Software programs the prescaler, then the interval reload value with its update flag set, then enables the interrupt, and finally writes the start bits. The interrupt handler clears the status flag. For single-shot use it re-arms the timer; in auto-repeat mode it leaves the timer alone.

Top module: `tick_timer`

## Requirements
- R1: After reset every register reads 0 and `irq` is low.
- R2: With prescaler value P (offset 0x00) and interval reload N ≥ 1, the first expiry happens on the (P+1)·N-th rising clock edge after the edge that writes control bits 0 and 1 both to 1.
- R3: A write to offset 0x08 loads bits 30:0 into the interval reload register only when bit 31 of the written value is 1. Otherwise the reload register keeps its value. The register reads back as {0, reload}.
- R4: When control bit 2 (auto-repeat) is 1, expiries repeat every (P+1)·N clocks and the control register keeps its value.
- R5: When control bit 2 is 0, the expiry clears control bits 1:0 and no further expiry follows.
- R6: Bit 0 of the status register (offset 0x30) is set on expiry. Writing a 1 to it clears it.
- R7: `irq` equals status bit 0 AND bit 0 of the enable register (offset 0x34). Status is still recorded while the enable bit is 0.
- R8: The write-status register (offset 0x40) sets bit 0 on any write to 0x00, bit 1 on any write to 0x08 (whatever bit 31 holds) and bit 3 on any write to the control register at 0x20. A bit stays set until a 1 is written to it at 0x40.
- R9: Counting needs control bits 0 and 1 both set. While either is clear, both counters hold their reload values. A restart therefore counts a full (P+1)·N period.
- R10: An interval reload value of 0 behaves like 1: the timer expires on every prescaled tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Byte offset within the register slot |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| irq | output | 1 | Interrupt output |

## Verification
The case that is hardest to set up is an exact expiry period that repeats across reloads in auto-repeat mode. The status clear has to fit inside one period, and the second expiry must still come exactly (P+1)·N clocks after the first. The bench uses a short period, counts clock edges from the start write, and clears the status between expiries so that both edges can be seen on `irq`. It then stops the timer in the middle of a period and restarts it, to show that the restart counts a full period from the buffers and does not resume the partial count.

// File: rtl/tick_timer.sv
module tick_timer #(
  parameter int AW = 8,
  parameter int PW = 32,
  parameter int RW = 31
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  output logic          irq
);
  localparam logic [AW-1:0] A_PRESC  = AW'('h00);
  localparam logic [AW-1:0] A_RELOAD = AW'('h08);
  localparam logic [AW-1:0] A_CTRL   = AW'('h20);
  localparam logic [AW-1:0] A_STS    = AW'('h30);
  localparam logic [AW-1:0] A_IEN    = AW'('h34);
  localparam logic [AW-1:0] A_WACK   = AW'('h40);

  logic [PW-1:0] presc_q, presc_cnt;
  logic [RW-1:0] reload_q, int_cnt;
  logic [2:0]    ctrl_q;
  logic          ien_q, sts_q;
  logic [2:0]    wack_q;

  wire wr_presc  = wr_en && addr == A_PRESC;
  wire wr_reload = wr_en && addr == A_RELOAD;
  wire wr_ctrl   = wr_en && addr == A_CTRL;
  wire wr_sts    = wr_en && addr == A_STS;
  wire wr_ien    = wr_en && addr == A_IEN;
  wire wr_wack   = wr_en && addr == A_WACK;

  wire running = ctrl_q[0] & ctrl_q[1];
  wire tick    = running && presc_cnt == '0;
  wire expire  = tick && int_cnt <= RW'(1);

  assign irq = sts_q & ien_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc_q  <= '0;
      reload_q <= '0;
      ctrl_q   <= '0;
      ien_q    <= 1'b0;
      sts_q    <= 1'b0;
      wack_q   <= '0;
    end else begin
      if (wr_presc) presc_q <= wdata[PW-1:0];
      if (wr_reload && wdata[31]) reload_q <= wdata[RW-1:0];
      if (wr_ien) ien_q <= wdata[0];
      if (wr_ctrl) ctrl_q <= wdata[2:0];
      else if (expire && !ctrl_q[2]) ctrl_q[1:0] <= 2'b00;
      if (expire) sts_q <= 1'b1;
      else if (wr_sts && wdata[0]) sts_q <= 1'b0;
      wack_q <= (wack_q & ~(wr_wack ? {wdata[3], wdata[1:0]} : 3'b000))
              | {wr_ctrl, wr_reload, wr_presc};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc_cnt <= '0;
      int_cnt   <= '0;
    end else if (!running) begin
      presc_cnt <= presc_q;
      int_cnt   <= reload_q;
    end else if (tick) begin
      presc_cnt <= presc_q;
      int_cnt   <= expire ? reload_q : int_cnt - RW'(1);
    end else begin
      presc_cnt <= presc_cnt - PW'(1);
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_PRESC:  rdata = 32'(presc_q);
      A_RELOAD: rdata = 32'(reload_q);
      A_CTRL:   rdata = {29'd0, ctrl_q};
      A_STS:    rdata = {31'd0, sts_q};
      A_IEN:    rdata = {31'd0, ien_q};
      A_WACK:   rdata = {28'd0, wack_q[2], 1'b0, wack_q[1:0]};
      default:  rdata = '0;
    endcase
  end

  AST_STS_ON_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> sts_q); // R6
  AST_ONESHOT_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !ctrl_q[2] && !wr_ctrl) |=> !running); // R5
  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    !running |=> int_cnt == $past(reload_q) && presc_cnt == $past(presc_q)); // R9
  AST_RELOAD_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_reload && !wdata[31]) |=> $stable(reload_q)); // R3
  AST_WACK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_wack |=> (wack_q & $past(wack_q)) == $past(wack_q)); // R8
  AST_REPEAT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && ctrl_q[2] && !wr_ctrl) |=> running); // R4
endmodule

// File: tb/test_tick_timer.sv
module test_tick_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  tick_timer i_tick_timer (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
                           .wdata(wdata), .rdata(rdata), .irq(irq));

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; #0.5;
    d = rdata;
  endtask

  task automatic wait_irq(int limit, output int at);
    at = -1;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (irq) begin at = cyc; break; end
    end
  endtask

  task automatic t_reset;
    logic [31:0] d;
    logic [7:0] offs [6] = '{8'h00, 8'h08, 8'h20, 8'h30, 8'h34, 8'h40};
    foreach (offs[k]) begin rd(offs[k], d); chk("R1", d, 0); end
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_wack;
    logic [31:0] d;
    wr(8'h00, 2); rd(8'h40, d); chk("R8 presc ack", d, 1);
    wr(8'h08, 5); rd(8'h08, d); chk("R3 no update", d, 0);
    rd(8'h40, d); chk("R8 reload ack", d, 3);
    wr(8'h40, 1); rd(8'h40, d); chk("R8 w1c", d, 2);
    wr(8'h20, 0); rd(8'h40, d); chk("R8 ctrl ack", d, 10);
    wr(8'h40, 32'hF); rd(8'h40, d); chk("R8 clear all", d, 0);
    wr(8'h08, 32'hFFFF_FFFF); rd(8'h08, d); chk("R3 update", d, 32'h7FFF_FFFF);
  endtask

  task automatic t_oneshot;
    logic [31:0] d; int t0, t1;
    wr(8'h00, 2); wr(8'h08, 32'h8000_0004); wr(8'h34, 1);
    wr(8'h20, 3); t0 = cyc;
    wait_irq(100, t1);
    chk("R2 first expiry", t1 - t0, 12);
    rd(8'h20, d); chk("R5 start bits cleared", d, 0);
    wr(8'h30, 1); chk("R6 status cleared", irq, 0);
    rd(8'h30, d); chk("R6 status reads 0", d, 0);
    wait_irq(40, t1); chk("R5 no repeat", t1, -1);
  endtask

  task automatic t_gate;
    logic [31:0] d;
    wr(8'h34, 0); wr(8'h00, 0); wr(8'h08, 32'h8000_0003); wr(8'h20, 3);
    repeat (8) @(negedge clk);
    rd(8'h30, d); chk("R7 status without enable", d, 1);
    chk("R7 irq gated", irq, 0);
    wr(8'h34, 1); chk("R7 irq enabled", irq, 1);
    wr(8'h30, 1); chk("R6 clear", irq, 0);
  endtask

  task automatic t_interval;
    logic [31:0] d; int t0, t1, t2;
    wr(8'h00, 1); wr(8'h08, 32'h8000_0003);
    wr(8'h20, 7); t0 = cyc;
    wait_irq(100, t1); chk("R4 first", t1 - t0, 6);
    wr(8'h30, 1);
    wait_irq(100, t2); chk("R4 period", t2 - t1, 6);
    rd(8'h20, d); chk("R4 ctrl kept", d, 7);
    wr(8'h30, 1);
    repeat (2) @(negedge clk);
    wr(8'h20, 4); wr(8'h30, 1);
    wait_irq(30, t1); chk("R9 halted", t1, -1);
    wr(8'h20, 7); t0 = cyc;
    wait_irq(100, t1); chk("R9 fresh period", t1 - t0, 6);
    wr(8'h20, 0); wr(8'h30, 1);
  endtask

  task automatic t_zero;
    int t0, t1;
    wr(8'h00, 2); wr(8'h08, 32'h8000_0000);
    wr(8'h20, 3); t0 = cyc;
    wait_irq(100, t1); chk("R10 zero reload", t1 - t0, 3);
    wr(8'h30, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_wack;
    t_oneshot;
    t_gate;
    t_interval;
    t_zero;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule